// File: doc/BRIEF.md
# ADC Conversion Timing Sequencer

This block is the digital timing controller of a successive-approximation analog-to-digital converter. An 8-bit configuration register sets three things: the conversion-clock prescaler, the length of the programmable sampling phase, and the resolution. From these settings the sequencer drives the two sample-switch controls, steps a trial code to the DAC one bit at a time, and reads back a single-bit comparator decision.

A one-cycle start pulse, given while the block is idle, launches a conversion. The conversion runs in three stages:
- a buffered sampling stage of fixed length;
- a direct-connect sampling stage whose length is programmable;
- one bit decision per conversion-clock period, most significant bit first.

When the last bit is decided, the result is loaded right-justified and a done flag is raised. The conversion clock is not a separate clock. It is a one-cycle enable pulse in the bus-clock domain, restarted at every conversion.

Writing the configuration register at any time stops the running conversion and returns the block to idle. The write does not start a new conversion.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset the register reads 0x05 (prescaler 5, 10-bit mode, sample code 00). `busy`, `done`, `smp_buf` and `smp_direct` are 0, and `result` and `dac_code` are 0.
- R2: Register bits 4:0 hold PRS. One conversion-clock period lasts 2×(PRS+1) bus cycles, measured from the start edge. A full conversion therefore takes (2 + L2 + N)×2×(PRS+1) cycles from the start edge to `done`, where L2 is the second-phase length and N is the resolution.
- R3: The first sampling phase begins on the edge that accepts the start. It lasts exactly 2 conversion-clock periods, with `smp_buf` high and `smp_direct` low.
- R4: The second sampling phase follows at once, with `smp_direct` high. Register bits 6:5 = 00, 01, 10 and 11 make it 2, 4, 8 and 16 periods long.
- R5: After sampling, each bit is decided in its own conversion-clock period, MSB first. During that period `dac_code` shows the bits already kept with the current bit set. The bit is kept when `cmp_ge` is 1 at the end of the period. Outside the decision stage `dac_code` is 0.
- R6: Register bit 7 = 1 selects 8-bit conversion and 0 selects 10-bit conversion. The result is right-justified in the 10-bit `result`, and bits 9:8 are 0 in 8-bit mode.
- R7: On the edge that decides the last bit, `result` is loaded and `done` rises. Both hold until the next accepted start or register write.
- R8: A register write ends any conversion. On the next cycle `busy`, `done`, `smp_buf` and `smp_direct` are 0, and no conversion begins without a new start.
- R9: A start pulse while `busy` is 1 is ignored. The running conversion completes with unchanged timing.
- R10: `cfg_rdata` always returns the last value written, and a write is accepted in any state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_wdata | input | 8 | Write data: bit 7 resolution, bits 6:5 sample code, bits 4:0 prescaler |
| cfg_rdata | output | 8 | Current configuration register value |
| start | input | 1 | One-cycle conversion request |
| cmp_ge | input | 1 | Comparator: analog input at or above `dac_code` |
| smp_buf | output | 1 | First (buffered) sampling phase active |
| smp_direct | output | 1 | Second (direct-connect) sampling phase active |
| dac_code | output | 10 | Trial code for the DAC, right-justified |
| result | output | 10 | Last conversion result, right-justified |
| done | output | 1 | Result valid |
| busy | output | 1 | Conversion in progress |

## Verification
The bench builds the block with its default parameters: a 5-bit prescaler, a 2-bit sample code and 10/8-bit resolution. With these values it can drive both extremes of the prescaler (divide by 2 and by 64), all four second-phase lengths and both resolutions, within a run of a few thousand cycles. A behavioural model advances in bus cycles and decides bits against its own trial code, so any slip of a single cycle in a phase boundary shows up as a mismatch.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_SMP1 = 2'd1,
        PH_SMP2 = 2'd2,
        PH_CONV = 2'd3
    } phase_e;

    localparam int PRS_AT_RESET = 5;

endpackage

// File: rtl/adc_seq_presc.sv
module adc_seq_presc #(
    parameter int PRS_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [PRS_W-1:0] prs,
    output logic             tick
);
    localparam int CNT_W = PRS_W + 1;

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] last;

    always_comb begin
        last  = {prs, 1'b1};
        tick  = run && (cnt_q == last);
        cnt_d = cnt_q;
        if (!run) begin
            cnt_d = '0;
        end else if (cnt_q == last) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/adc_seq_sar.sv
module adc_seq_sar #(
    parameter int W     = 10,
    parameter int IDX_W = $clog2(W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             step,
    input  logic [IDX_W-1:0] idx,
    input  logic             keep,
    output logic [W-1:0]     trial,
    output logic [W-1:0]     acc_nxt
);
    logic [W-1:0] acc_d, acc_q;

    always_comb begin
        trial   = acc_q | (W'(1) << idx);
        acc_nxt = keep ? trial : acc_q;
        acc_d   = acc_q;
        if (clr) begin
            acc_d = '0;
        end else if (step) begin
            acc_d = acc_nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_d;
        end
    end

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int PRS_W    = 5,
    parameter int SMP_W    = 2,
    parameter int RES_HI   = 10,
    parameter int RES_LO   = 8,
    parameter int P1_TICKS = 2,
    localparam int CFG_W   = 1 + SMP_W + PRS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic [CFG_W-1:0]  cfg_rdata,
    input  logic              start,
    input  logic              cmp_ge,
    output logic              smp_buf,
    output logic              smp_direct,
    output logic [RES_HI-1:0] dac_code,
    output logic [RES_HI-1:0] result,
    output logic              done,
    output logic              busy
);
    localparam int IDX_W = $clog2(RES_HI);
    localparam int PH_W  = (1 << SMP_W) + 1;

    typedef struct packed {
        phase_e            phase;
        logic [PH_W-1:0]   ph_cnt;
        logic [IDX_W-1:0]  bit_idx;
        logic              done;
        logic [RES_HI-1:0] result;
        logic [CFG_W-1:0]  cfg;
    } seq_t;

    seq_t s_d, s_q;

    logic              tick;
    logic              sar_clr;
    logic              sar_step;
    logic [RES_HI-1:0] trial;
    logic [RES_HI-1:0] acc_nxt;
    logic [SMP_W-1:0]  smp_code;
    logic [PRS_W-1:0]  prs;
    logic              narrow;
    logic [PH_W-1:0]   p2_last;
    logic [IDX_W-1:0]  msb_idx;

    adc_seq_presc #(.PRS_W(PRS_W)) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (s_q.phase != PH_IDLE),
        .prs   (prs),
        .tick  (tick)
    );

    adc_seq_sar #(.W(RES_HI), .IDX_W(IDX_W)) u_sar (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (sar_clr),
        .step    (sar_step),
        .idx     (s_q.bit_idx),
        .keep    (cmp_ge),
        .trial   (trial),
        .acc_nxt (acc_nxt)
    );

    always_comb begin
        prs      = s_q.cfg[PRS_W-1:0];
        smp_code = s_q.cfg[PRS_W +: SMP_W];
        narrow   = s_q.cfg[CFG_W-1];
        p2_last  = PH_W'((32'd2 << smp_code) - 32'd1);
        msb_idx  = narrow ? IDX_W'(RES_LO - 1) : IDX_W'(RES_HI - 1);
        sar_clr  = (s_q.phase == PH_IDLE);
        sar_step = tick && (s_q.phase == PH_CONV);

        s_d = s_q;
        if (cfg_we) begin
            s_d.cfg    = cfg_wdata;
            s_d.phase  = PH_IDLE;
            s_d.done   = 1'b0;
            s_d.ph_cnt = '0;
        end else begin
            unique case (s_q.phase)
                PH_IDLE: begin
                    if (start) begin
                        s_d.phase  = PH_SMP1;
                        s_d.done   = 1'b0;
                        s_d.ph_cnt = '0;
                    end
                end
                PH_SMP1: begin
                    if (tick) begin
                        if (s_q.ph_cnt == PH_W'(P1_TICKS - 1)) begin
                            s_d.phase  = PH_SMP2;
                            s_d.ph_cnt = '0;
                        end else begin
                            s_d.ph_cnt = s_q.ph_cnt + PH_W'(1);
                        end
                    end
                end
                PH_SMP2: begin
                    if (tick) begin
                        if (s_q.ph_cnt == p2_last) begin
                            s_d.phase   = PH_CONV;
                            s_d.ph_cnt  = '0;
                            s_d.bit_idx = msb_idx;
                        end else begin
                            s_d.ph_cnt = s_q.ph_cnt + PH_W'(1);
                        end
                    end
                end
                PH_CONV: begin
                    if (tick) begin
                        if (s_q.bit_idx == '0) begin
                            s_d.phase  = PH_IDLE;
                            s_d.done   = 1'b1;
                            s_d.result = acc_nxt;
                        end else begin
                            s_d.bit_idx = s_q.bit_idx - IDX_W'(1);
                        end
                    end
                end
                default: s_d.phase = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.phase   <= PH_IDLE;
            s_q.ph_cnt  <= '0;
            s_q.bit_idx <= '0;
            s_q.done    <= 1'b0;
            s_q.result  <= '0;
            s_q.cfg     <= CFG_W'(PRS_AT_RESET);
        end else begin
            s_q <= s_d;
        end
    end

    assign cfg_rdata  = s_q.cfg;
    assign smp_buf    = (s_q.phase == PH_SMP1);
    assign smp_direct = (s_q.phase == PH_SMP2);
    assign dac_code   = (s_q.phase == PH_CONV) ? trial : '0;
    assign result     = s_q.result;
    assign done       = s_q.done;
    assign busy       = (s_q.phase != PH_IDLE);

endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk #(
    parameter int RES_HI = 10,
    parameter int RES_LO = 8,
    parameter int CFG_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic [CFG_W-1:0]  cfg_rdata,
    input logic              start,
    input logic              smp_buf,
    input logic              smp_direct,
    input logic [RES_HI-1:0] dac_code,
    input logic [RES_HI-1:0] result,
    input logic              done,
    input logic              busy
);

    p_start_launch_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && !cfg_we) |=> (busy && smp_buf && !smp_direct && !done));

    p_write_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (!busy && !done && !smp_buf && !smp_direct && dac_code == '0));

    p_one_stage_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({smp_buf, smp_direct, |dac_code}));

    p_done_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start && !cfg_we) |=> (done && $stable(result)));

    p_narrow_top_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cfg_rdata[CFG_W-1]) |-> (result[RES_HI-1:RES_LO] == '0));

    p_cfg_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(cfg_rdata));

    p_no_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_direct && start && !cfg_we) |=> !smp_buf);

    p_idle_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (dac_code == '0 && !smp_buf && !smp_direct));

endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(
    .RES_HI (RES_HI),
    .RES_LO (RES_LO),
    .CFG_W  (CFG_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_rdata  (cfg_rdata),
    .start      (start),
    .smp_buf    (smp_buf),
    .smp_direct (smp_direct),
    .dac_code   (dac_code),
    .result     (result),
    .done       (done),
    .busy       (busy)
);

// File: tb/adc_seq_ctrl_bench.sv
`timescale 1ns/1ps
module adc_seq_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic [7:0] cfg_rdata;
    logic       start = 1'b0;
    logic       cmp_ge;
    logic       smp_buf, smp_direct, done, busy;
    logic [9:0] dac_code, result;
    logic [9:0] vin = 10'd0;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    always #2 clk = ~clk;

    assign cmp_ge = (vin >= dac_code);

    adc_seq_ctrl u_adc_seq_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .start      (start),
        .cmp_ge     (cmp_ge),
        .smp_buf    (smp_buf),
        .smp_direct (smp_direct),
        .dac_code   (dac_code),
        .result     (result),
        .done       (done),
        .busy       (busy)
    );

    // behavioural reference: stage 0 idle, 1 buffered, 2 direct, 3 deciding
    int         m_stage, m_left, m_bit;
    logic [9:0] m_acc, m_res;
    logic       m_done;
    logic [7:0] m_cfg;

    function automatic int m_div();
        return 2 * (int'(m_cfg[4:0]) + 1);
    endfunction

    function automatic logic [9:0] m_trial();
        return (m_stage == 3) ? (m_acc | (10'd1 << m_bit)) : 10'd0;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_stage = 0; m_left = 0; m_bit = 0;
            m_acc = '0; m_res = '0; m_done = 1'b0; m_cfg = 8'h05;
        end else if (cfg_we) begin
            m_cfg = cfg_wdata; m_stage = 0; m_done = 1'b0;
        end else begin
            case (m_stage)
                0: if (start) begin
                    m_stage = 1; m_left = 2 * m_div(); m_done = 1'b0; m_acc = '0;
                end
                1: begin
                    m_left--;
                    if (m_left == 0) begin
                        m_stage = 2;
                        m_left = (2 << m_cfg[6:5]) * m_div();
                    end
                end
                2: begin
                    m_left--;
                    if (m_left == 0) begin
                        m_stage = 3; m_acc = '0; m_left = m_div();
                        m_bit = m_cfg[7] ? 7 : 9;
                    end
                end
                default: begin
                    m_left--;
                    if (m_left == 0) begin
                        if (vin >= m_trial()) m_acc = m_trial();
                        if (m_bit == 0) begin
                            m_res = m_acc; m_done = 1'b1; m_stage = 0;
                        end else begin
                            m_bit--; m_left = m_div();
                        end
                    end
                end
            endcase
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R3 smp_buf", smp_buf, m_stage == 1);
            chk("R4 smp_direct", smp_direct, m_stage == 2);
            chk("R5 dac_code", dac_code, m_trial());
            chk("R6 result", result, m_res);
            chk("R7 done", done, m_done);
            chk("R8 busy", busy, m_stage != 0);
            chk("R10 cfg_rdata", cfg_rdata, m_cfg);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected<150000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic wr(input logic [7:0] v);
        @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic wait_done(output int n);
        n = 0;
        while (!done && n < 5000) begin
            @(negedge clk); n++;
        end
    endtask

    // one full conversion; checks duration (R2) and value (R5/R6)
    task automatic conv(input logic [7:0] cfg, input logic [9:0] v);
        int n, div, l2, nb, exp_n;
        logic [9:0] exp_v;
        wr(cfg);
        vin = v;
        div = 2 * (int'(cfg[4:0]) + 1);
        l2  = 2 << cfg[6:5];
        nb  = cfg[7] ? 8 : 10;
        exp_n = (2 + l2 + nb) * div;
        exp_v = cfg[7] ? ((v > 10'd255) ? 10'd255 : v) : v;
        pulse_start();
        wait_done(n);
        chk("R2 conversion cycles", n, exp_n);
        chk("R5 result value", result, exp_v);
        if (cfg[7]) chk("R6 upper bits zero", result[9:8], 0);
    endtask

    initial begin
        int n;
        repeat (3) @(negedge clk);
        chk("R1 cfg reset", cfg_rdata, 8'h05);
        chk("R1 busy reset", busy, 0);
        chk("R1 done reset", done, 0);
        chk("R1 result reset", result, 0);
        chk("R1 dac reset", dac_code, 0);
        chk("R1 sample reset", {smp_buf, smp_direct}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // default register: prescaler 5, 10-bit, short sample
        vin = 10'd613;
        pulse_start();
        wait_done(n);
        chk("R2 default cycles", n, 14 * 12);
        chk("R5 default value", result, 613);

        conv(8'h00, 10'd1023);  // fastest clock, R4 code 00
        conv(8'h20, 10'd0);     // R4 code 01
        conv(8'h41, 10'd512);   // R4 code 10
        conv(8'h7f, 10'd341);   // R4 code 11, slowest clock
        conv(8'h80, 10'd200);   // R6 8-bit
        conv(8'hc2, 10'd900);   // R6 8-bit saturating

        // R7: done and result hold while idle
        repeat (20) @(negedge clk);
        chk("R7 done held", done, 1);
        chk("R7 result held", result, 255);

        // R9: start during sampling ignored, timing unchanged
        wr(8'h01);
        vin = 10'd77;
        pulse_start();
        repeat (5) @(negedge clk);
        start = 1'b1; @(negedge clk); start = 1'b0;
        wait_done(n);
        chk("R9 timing after extra start", n + 6, 14 * 4);
        chk("R9 value after extra start", result, 77);

        // R8: write mid-conversion aborts, nothing restarts
        wr(8'h03);
        pulse_start();
        repeat (30) @(negedge clk);
        wr(8'h83);
        chk("R8 busy after abort", busy, 0);
        chk("R8 done after abort", done, 0);
        repeat (200) @(negedge clk);
        chk("R8 still idle", busy, 0);
        chk("R10 readback", cfg_rdata, 8'h83);

        // R8: write with start in the same cycle starts nothing
        @(negedge clk); cfg_we = 1'b1; cfg_wdata = 8'h00; start = 1'b1;
        @(negedge clk); cfg_we = 1'b0; start = 1'b0;
        chk("R8 write beats start", busy, 0);

        // R10: write accepted at any point
        conv(8'he3, 10'd45);
        chk("R10 readback e3", cfg_rdata, 8'he3);

        repeat (4) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule